// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

A compact multi-cycle processor controller that runs a small accumulator instruction set. Each instruction moves through explicit register transfers. The program counter goes to the memory address register. Memory returns the word into the memory buffer register, which is then copied into the current instruction register. The sequencer then decodes the instruction and executes it. Code and data share one synchronous memory port that has one cycle of read latency.

Each instruction word is split into an opcode, a mode bit and an operand. With the mode bit set, the operand is used as a literal. With it clear, the operand names a memory word, and that word is fetched through the address and buffer registers before the instruction executes. An interrupt input sets a pending flag. Between instructions the sequencer checks this flag. If it is set, it saves the program counter, clears the flag and jumps to a fixed vector.

Top module: `accum_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, zero and carry flags, pending-interrupt flag and saved PC. After reset the sequencer starts a fetch from address 0, with `mem_we` low and `halted` low.
- R2: Each instruction is fetched in this order: PC to MAR, one wait cycle with MAR on `mem_addr`, read data into MBR with PC incremented by one, then MBR to CIR, then decode. Instruction timings are:
  - immediate LOAD/ALU instruction: 7 cycles
  - direct LOAD/ALU instruction: 9 cycles
  - STORE: 7 cycles
  - JUMP: 6 cycles
  - unused opcode: 6 cycles
  - HALT: reaches the halted state 5 cycles after its fetch begins
- R3: The instruction word has three fields. Bits 15:12 hold the opcode, bit 11 holds the mode (1 = immediate) and bits 10:0 hold the operand. The opcodes are LOAD=1, STORE=2, ADD=3, SUB=4, AND=5, OR=6, XOR=7, JUMP=8 and HALT=15.
- R4: In immediate mode, the 11-bit operand is zero-extended to 16 bits and used as the data value.
- R5: In direct mode, the operand is a memory address. The 16-bit word stored there is read through MAR and MBR and then used as the data value.
- R6: LOAD copies the data value into the accumulator. ADD, SUB, AND, OR and XOR each combine the accumulator with the data value and write the 16-bit result back to the accumulator.
- R7: Every LOAD or ALU instruction sets the zero flag exactly when its result is 0. ADD sets carry to the carry out. SUB sets carry to the borrow (accumulator below the data value). The logic operations clear carry. LOAD leaves carry unchanged.
- R8: STORE writes the accumulator to the operand address, with `mem_we` high for a single cycle. The mode bit has no effect on STORE.
- R9: JUMP loads the PC with the operand, and the next fetch reads from that address.
- R10: After HALT the sequencer is frozen until reset. The PC no longer changes, later instructions neither run nor write, and a pending interrupt is never serviced.
- R11: A high `irq` sets the pending flag. After each instruction, before the next fetch, a set flag is serviced: the PC is copied to `saved_pc`, the flag is cleared and the PC becomes 0x7F0.
- R12: An opcode outside the listed set does nothing. It leaves the accumulator and flags unchanged and continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 11 | Memory address, driven from MAR |
| mem_wdata | output | 16 | Memory write data, driven from MBR |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| irq | input | 1 | Interrupt request; sets the pending flag |
| pc | output | 11 | Program counter |
| acc | output | 16 | Accumulator |
| zero_flag | output | 1 | Zero flag of the status register |
| carry_flag | output | 1 | Carry/borrow flag of the status register |
| irq_pending | output | 1 | Pending-interrupt flag of the status register |
| saved_pc | output | 11 | PC saved on interrupt entry |
| halted | output | 1 | High once HALT has executed |

## Verification
Every ALU opcode is run in both addressing modes against operand pairs chosen for their corner behaviour:
- zero plus zero and equal operands, which produce the zero flag
- all ones plus one, which produces a carry that wraps to zero
- sign-bit sums
- a smaller minus a larger value, which produces a borrow
- complementary bit patterns, which separate AND, OR and XOR

In immediate mode only the low 11 bits of the second operand survive. That separates zero-extension from a memory read. Cycle counts to halt pin down the wait state and the per-instruction timing. Separate programs check jumps, unused opcodes, interrupt entry in the middle of a program, and an interrupt raised while halted.

// File: rtl/accum_cpu.sv
module accum_cpu #(
  parameter int DW = 16,
  parameter logic [DW-6:0] VECTOR = 11'h7F0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-6:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  input  logic          irq,
  output logic [DW-6:0] pc,
  output logic [DW-1:0] acc,
  output logic          zero_flag,
  output logic          carry_flag,
  output logic          irq_pending,
  output logic [DW-6:0] saved_pc,
  output logic          halted
);
  localparam int AW = DW - 5;
  localparam logic [3:0] OP_LOAD = 4'd1, OP_STORE = 4'd2, OP_ADD = 4'd3, OP_SUB = 4'd4,
                         OP_AND = 4'd5, OP_OR = 4'd6, OP_XOR = 4'd7, OP_JUMP = 4'd8,
                         OP_HALT = 4'd15;

  typedef enum logic [3:0] {
    S_FMAR, S_FWAIT, S_FMBR, S_FCIR, S_DEC, S_OWAIT, S_OMBR, S_EXEC, S_STORE, S_INT, S_HALT
  } st_t;

  st_t st;
  logic [AW-1:0] mar;
  logic [DW-1:0] mbr, cir, res;
  logic cout;

  wire [3:0]    opc  = cir[DW-1:DW-4];
  wire          imm  = cir[DW-5];
  wire [AW-1:0] opnd = cir[AW-1:0];
  wire          uses_data = (opc >= OP_LOAD && opc <= OP_XOR && opc != OP_STORE);

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (st == S_STORE);
  assign halted    = (st == S_HALT);

  always_comb begin
    cout = carry_flag;
    res  = mbr;
    case (opc)
      OP_ADD: {cout, res} = {1'b0, acc} + {1'b0, mbr};
      OP_SUB: {cout, res} = {1'b0, acc} - {1'b0, mbr};
      OP_AND: begin res = acc & mbr; cout = 1'b0; end
      OP_OR:  begin res = acc | mbr; cout = 1'b0; end
      OP_XOR: begin res = acc ^ mbr; cout = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FMAR;
      pc <= '0; mar <= '0; mbr <= '0; cir <= '0; acc <= '0;
      zero_flag <= 1'b0; carry_flag <= 1'b0; irq_pending <= 1'b0; saved_pc <= '0;
    end else begin
      if (irq) irq_pending <= 1'b1;
      case (st)
        S_FMAR:  begin mar <= pc; st <= S_FWAIT; end
        S_FWAIT: st <= S_FMBR;
        S_FMBR:  begin mbr <= mem_rdata; pc <= pc + 1'b1; st <= S_FCIR; end
        S_FCIR:  begin cir <= mbr; st <= S_DEC; end
        S_DEC: begin
          if (uses_data) begin
            if (imm) begin mbr <= DW'(opnd); st <= S_EXEC; end
            else begin mar <= opnd; st <= S_OWAIT; end
          end else if (opc == OP_STORE) begin
            mar <= opnd; mbr <= acc; st <= S_STORE;
          end else if (opc == OP_JUMP) begin
            pc <= opnd; st <= S_INT;
          end else if (opc == OP_HALT) st <= S_HALT;
          else st <= S_INT;
        end
        S_OWAIT: st <= S_OMBR;
        S_OMBR:  begin mbr <= mem_rdata; st <= S_EXEC; end
        S_EXEC: begin
          acc <= res; zero_flag <= (res == '0); carry_flag <= cout; st <= S_INT;
        end
        S_STORE: st <= S_INT;
        S_INT: begin
          if (irq_pending) begin
            saved_pc <= pc; pc <= VECTOR; irq_pending <= irq;
          end
          st <= S_FMAR;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && !irq_pending && !zero_flag && !carry_flag && !mem_we));
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FMBR) |=> (pc == $past(pc) + 1'b1));
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC) |=> (zero_flag == (acc == '0)));
  p_store_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && !mem_we));
  p_vector_r11: assert property (@(posedge clk) disable iff (rst)
    (st == S_INT && irq_pending) |=> (pc == VECTOR && saved_pc == $past(pc)));
endmodule

// File: tb/accum_cpu_test.sv
module accum_cpu_test;
  logic clk = 1'b0, rst = 1'b1, irq = 1'b0;
  logic [10:0] mem_addr, pc, saved_pc;
  logic [15:0] mem_wdata, mem_rdata, acc;
  logic mem_we, zero_flag, carry_flag, irq_pending, halted;
  logic ld_en = 1'b0;
  logic [10:0] ld_a = '0;
  logic [15:0] ld_d = '0;
  logic [15:0] tmem [0:2047];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  accum_cpu uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .irq(irq), .pc(pc), .acc(acc), .zero_flag(zero_flag),
    .carry_flag(carry_flag), .irq_pending(irq_pending), .saved_pc(saved_pc), .halted(halted)
  );

  always @(posedge clk) begin
    if (ld_en) tmem[ld_a] <= ld_d;
    else if (mem_we) tmem[mem_addr] <= mem_wdata;
    mem_rdata <= tmem[mem_addr];
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic im, input logic [10:0] o);
    return {op, im, o};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk); ld_en = 1'b1; ld_a = a; ld_d = d;
  endtask

  task automatic begin_load();
    @(negedge clk); rst = 1'b1; irq = 1'b0;
  endtask

  task automatic run(input int irq_at, output int n);
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk); rst = 1'b0;
    n = 0;
    while (!halted && n < 300) begin
      @(negedge clk);
      n++;
      irq = (n == irq_at);
    end
    irq = 1'b0;
  endtask

  initial begin
    int n;
    logic [15:0] a_v [6] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h1234, 16'h0001, 16'hAAAA};
    logic [15:0] b_v [6] = '{16'h0000, 16'h0001, 16'h8000, 16'h0F0F, 16'h0002, 16'h5555};

    // R1: reset state
    begin_load();
    poke(11'h000, ins(4'd15, 1'b0, 11'h0));
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk);
    chk(pc == 0 && acc == 0 && !zero_flag && !carry_flag && !irq_pending && saved_pc == 0,
        "R1 reset registers", {pc, acc}, 0);
    chk(mem_addr == 0 && !mem_we && !halted, "R1 fetch from 0", {mem_addr, mem_we, halted}, 0);

    // R2-R8: ALU sweep, both modes
    for (int op = 3; op <= 7; op++) begin
      for (int md = 0; md < 2; md++) begin
        for (int k = 0; k < 6; k++) begin
          logic [15:0] a, b, r;
          logic c;
          a = a_v[k];
          b = md ? {5'b0, b_v[k][10:0]} : b_v[k];
          case (op)
            3: {c, r} = {1'b0, a} + {1'b0, b};
            4: {c, r} = {1'b0, a} - {1'b0, b};
            5: begin r = a & b; c = 1'b0; end
            6: begin r = a | b; c = 1'b0; end
            default: begin r = a ^ b; c = 1'b0; end
          endcase
          begin_load();
          poke(11'h000, ins(4'd1, 1'b0, 11'h100));
          poke(11'h001, ins(op[3:0], md[0], md ? b_v[k][10:0] : 11'h101));
          poke(11'h002, ins(4'd2, md[0], 11'h200));
          poke(11'h003, ins(4'd15, 1'b0, 11'h0));
          poke(11'h100, a);
          poke(11'h101, b_v[k]);
          poke(11'h200, 16'hDEAD);
          run(-1, n);
          chk(acc == r, md ? "R4 R6 immediate result" : "R5 R6 direct result", acc, r);
          chk(zero_flag == (r == 0) && carry_flag == c, "R7 flags",
              {zero_flag, carry_flag}, {(r == 0), c});
          chk(tmem[11'h200] == r, "R8 store", tmem[11'h200], r);
          chk(n == (md ? 28 : 30) && pc == 11'd4, "R2 R3 timing and pc",
              {n[15:0], 5'b0, pc}, {(md ? 16'd28 : 16'd30), 16'd4});
        end
      end
    end

    // R7: LOAD keeps carry, updates zero
    begin_load();
    poke(11'h000, ins(4'd1, 1'b1, 11'h7FF));
    poke(11'h001, ins(4'd3, 1'b0, 11'h100));
    poke(11'h002, ins(4'd1, 1'b1, 11'h000));
    poke(11'h003, ins(4'd15, 1'b0, 11'h0));
    poke(11'h100, 16'hF801);
    run(-1, n);
    chk(acc == 0 && zero_flag && carry_flag, "R7 load keeps carry",
        {acc, zero_flag, carry_flag}, {16'h0, 2'b11});

    // R9: jump
    begin_load();
    poke(11'h000, ins(4'd8, 1'b0, 11'h040));
    poke(11'h001, ins(4'd1, 1'b1, 11'h0AA));
    poke(11'h040, ins(4'd1, 1'b1, 11'h007));
    poke(11'h041, ins(4'd15, 1'b0, 11'h0));
    run(-1, n);
    chk(acc == 16'd7 && pc == 11'h042 && n == 18, "R9 jump", {acc, 5'b0, pc}, {16'd7, 16'h042});

    // R12: unused opcode is a no-op
    begin_load();
    poke(11'h000, ins(4'd1, 1'b1, 11'h033));
    poke(11'h001, ins(4'd11, 1'b1, 11'h000));
    poke(11'h002, ins(4'd15, 1'b0, 11'h0));
    run(-1, n);
    chk(acc == 16'h33 && !zero_flag && pc == 11'd3 && n == 18, "R12 no-op",
        {acc, 5'b0, pc}, {16'h33, 16'd3});

    // R11: interrupt serviced after the first instruction
    begin_load();
    poke(11'h000, ins(4'd1, 1'b1, 11'h005));
    poke(11'h001, ins(4'd3, 1'b1, 11'h003));
    poke(11'h002, ins(4'd15, 1'b0, 11'h0));
    poke(11'h7F0, ins(4'd15, 1'b0, 11'h0));
    run(2, n);
    chk(saved_pc == 11'd1 && pc == 11'h7F1, "R11 vector and saved pc",
        {5'b0, saved_pc, 5'b0, pc}, {16'd1, 16'h7F1});
    chk(acc == 16'd5 && !irq_pending && n == 12, "R11 flag cleared",
        {acc, 15'b0, irq_pending}, {16'd5, 16'd0});

    // R10: halt freeze, store after halt never runs, irq not serviced
    begin_load();
    poke(11'h000, ins(4'd15, 1'b0, 11'h0));
    poke(11'h001, ins(4'd2, 1'b0, 11'h200));
    poke(11'h200, 16'h5A5A);
    run(-1, n);
    chk(n == 5 && halted, "R10 halt timing", n, 5);
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    repeat (20) @(negedge clk);
    chk(halted && pc == 11'd1 && saved_pc == 0 && irq_pending, "R10 frozen",
        {5'b0, pc, 5'b0, saved_pc}, {16'd1, 16'd0});
    chk(tmem[11'h200] == 16'h5A5A, "R10 no write", tmem[11'h200], 16'h5A5A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule